// File: doc/BRIEF.md
# Masked-Write PHY Control Register File

This block is a small register file for a storage PHY's control interface. Seven 32-bit control registers drive the PHY's configuration pins, and one status register, which cannot be written, shows the PHY's state back to software. A simple synchronous bus reaches the file. The bus carries a word address, write data, a write strobe, a read strobe and registered read data.

Writes need no read-modify-write. The upper sixteen bits of each write word are a per-bit enable for the lower sixteen bits. A stored bit changes only when its enable bit is set. Software can therefore flip a single control bit, such as the power-up or delay-line enable, without disturbing its neighbours. The enable bits are never stored. The upper half of every control register reads as zero.

Top module: `phy_ctl_regs`

## Requirements
- R1: A write to a control register sets stored bit x (x from 0 to 15) to wdata[x] only when wdata[x+16] is 1. All other stored bits keep their value.
- R2: The control registers are at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 (register k at 4*k). Each register can be read back at its offset.
- R3: Bits 31:16 of every control register read as zero.
- R4: A read of byte offset 0x20 returns the live `status_in` value.
- R5: Writes to offset 0x20 and writes to unmapped offsets change no control register.
- R6: Reads of unmapped offsets return zero.
- R7: After reset all control bits are 0, so `pwr_on` (bit 0 of offset 0x18) and `dly_en` (bit 1 of offset 0x18) are low.
- R8: `rdata` updates on the clock edge that samples `rd_en` and holds its value until the next read.
- R9: `pwr_on` equals bit 0 and `dly_en` equals bit 1 of the register at 0x18. `cal_done` is status bit 6 and `dly_rdy` is status bit 5 of `status_in`.
- R10: A write takes effect on the clock edge that samples `wr_en`. The `ctrl_out` bus carries register k's low half in bits [16k+15:16k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Byte address (bits 1:0 ignored) |
| wdata | input | 32 | Write word: [31:16] enables, [15:0] values |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| status_in | input | 32 | Status word from the PHY |
| ctrl_out | output | 112 | Low halves of the seven control registers |
| pwr_on | output | 1 | PHY power-up enable |
| dly_en | output | 1 | Delay-line enable |
| cal_done | output | 1 | Calibration complete |
| dly_rdy | output | 1 | Delay line ready |

## Verification
Assertions check on every cycle that stored bits with a clear enable keep their value across a write. They also check that bits with a set enable take the written value, that unmapped or status writes leave all registers alone, and that read data holds when no read occurs. The bench checks address decoding, the zero upper half, the live status readback, the reset state and the named control bits. These are checked only at particular points: it sweeps every offset and every enable bit one by one against a model of the register contents.

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs #(
  parameter int NREG = 7,
  parameter int AW   = 6,
  parameter int HW   = 16,
  parameter int STAT_IDX = 8,
  parameter int PWR_IDX  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [2*HW-1:0]   wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [2*HW-1:0]   rdata,
  input  logic [2*HW-1:0]   status_in,
  output logic [NREG*HW-1:0] ctrl_out,
  output logic              pwr_on,
  output logic              dly_en,
  output logic              cal_done,
  output logic              dly_rdy
);
  localparam int DW = 2 * HW;
  localparam int IW = AW - 2;

  logic [HW-1:0] regs [NREG];
  logic [IW-1:0] idx;
  logic [HW-1:0] wmask, wval;
  logic [DW-1:0] rd_mux;

  assign idx   = addr[AW-1:2];
  assign wmask = wdata[DW-1:HW];
  assign wval  = wdata[HW-1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[k] <= '0;
      else if (wr_en && idx == IW'(k))
        regs[k] <= (regs[k] & ~wmask) | (wval & wmask);
    end
    assign ctrl_out[k*HW +: HW] = regs[k];

    a_r1_keep_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IW'(k)) |=> ((regs[k] & ~$past(wmask)) == ($past(regs[k]) & ~$past(wmask))));
    a_r1_take_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IW'(k)) |=> ((regs[k] & $past(wmask)) == ($past(wval) & $past(wmask))));
    a_r5_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && idx == IW'(k)) |=> $stable(regs[k]));
  end

  always_comb begin
    rd_mux = '0;
    if (idx == IW'(STAT_IDX))
      rd_mux = status_in;
    else if (int'(idx) < NREG)
      rd_mux = {{HW{1'b0}}, regs[idx[$clog2(NREG)-1:0]]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(idx) < NREG) |=> (rdata[DW-1:HW] == '0));

  assign pwr_on   = regs[PWR_IDX][0];
  assign dly_en   = regs[PWR_IDX][1];
  assign cal_done = status_in[6];
  assign dly_rdy  = status_in[5];
endmodule

// File: tb/phy_ctl_regs_bench.sv
module phy_ctl_regs_bench;
  logic clk = 0, rst_n = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, status_in = 0, rdata;
  logic wr_en = 0, rd_en = 0;
  logic [111:0] ctrl_out;
  logic pwr_on, dly_en, cal_done, dly_rdy;
  int checks = 0, errors = 0;
  logic [15:0] model [7];
  bit done = 0;

  always #2 clk = ~clk;

  phy_ctl_regs u_phy_ctl_regs (.clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .rdata,
    .status_in, .ctrl_out, .pwr_on, .dly_en, .cal_done, .dly_rdy);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a[5:2] < 7)
      model[a[5:2]] = (model[a[5:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    for (int k = 0; k < 7; k++) begin
      rd(6'(4*k), d);
      chk(req, d, {16'h0, model[k]});
      chk("R10", {16'h0, ctrl_out[16*k +: 16]}, {16'h0, model[k]});
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 7; k++) model[k] = 0;
    #9 rst_n = 1;
    chk("R7 pwr", {31'h0, pwr_on}, 0);
    chk("R7 dly", {31'h0, dly_en}, 0);
    check_all("R7");
    // R1 / R2: per-bit sweep on each register
    for (int k = 0; k < 7; k++)
      for (int b = 0; b < 16; b++) begin
        wr(6'(4*k), (32'h1 << (b + 16)) | 32'h0000ffff);
        rd(6'(4*k), d);
        chk("R1 set", d, {16'h0, model[k]});
      end
    check_all("R2");
    // Unmasked write changes nothing (R1)
    wr(6'h00, 32'h0000_0000);
    check_all("R1 nomask");
    // Mixed patterns; R3 upper zero
    for (int k = 0; k < 7; k++) begin
      wr(6'(4*k), {16'ha5c3 ^ 16'(k*16'h1111), 16'h1234 + 16'(k)});
      wr(6'(4*k), 32'hffff_0000 | 32'(16'h0f0f << k));
    end
    check_all("R3");
    // R5: writes to status and unmapped offsets ignored
    wr(6'h20, 32'hffff_ffff);
    wr(6'h1c, 32'hffff_0000);
    wr(6'h3c, 32'hffff_aaaa);
    check_all("R5");
    // R6 unmapped reads
    rd(6'h1c, d); chk("R6 1c", d, 0);
    rd(6'h24, d); chk("R6 24", d, 0);
    rd(6'h3c, d); chk("R6 3c", d, 0);
    // R4 / R9 status
    status_in = 32'hdead_beef;
    rd(6'h20, d); chk("R4", d, 32'hdead_beef);
    status_in = 32'h0000_0040;
    #1 chk("R9 cal", {30'h0, cal_done, dly_rdy}, 32'h2);
    status_in = 32'h0000_0020;
    #1 chk("R9 rdy", {30'h0, cal_done, dly_rdy}, 32'h1);
    // R9 power sequence
    wr(6'h18, 32'h0003_0000);
    chk("R9 off", {30'h0, dly_en, pwr_on}, 0);
    wr(6'h18, 32'h0001_0001);
    chk("R9 pwr", {30'h0, dly_en, pwr_on}, 1);
    wr(6'h18, 32'h0002_0002);
    chk("R9 both", {30'h0, dly_en, pwr_on}, 3);
    // R10 timing: visible right after the write edge
    @(negedge clk); addr = 6'h0; wdata = 32'hffff_5a5a; wr_en = 1;
    @(posedge clk); #1;
    chk("R10 edge", {16'h0, ctrl_out[15:0]}, 32'h5a5a);
    @(negedge clk); wr_en = 0; model[0] = 16'h5a5a;
    // R8: rdata holds without read
    rd(6'h00, d);
    wr(6'h00, 32'hffff_0000); model[0] = 0;
    @(negedge clk); chk("R8 hold", rdata, 32'h5a5a);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule